// File: doc/BRIEF.md
# 32-Source Prioritising Interrupt Controller

This block gathers up to 32 asynchronous interrupt lines and presents them to a processor through a small register window on a plain memory-mapped bus. Each line is brought into the clock domain by a two-flop synchronizer. Each line can be sensed as a level or as a transition, and either voltage sense can be chosen as the active one. A line that fires latches a pending bit. Software clears a pending bit by writing a one to it.

The pending bits are gated by an enable mask. Each surviving bit is then steered to one of two request outputs: the ordinary interrupt request or the machine-check request. A fixed-priority encoder reports the lowest-numbered enabled pending line. It reports 32 when none is pending. Three line numbers (17, 18 and 19) are reserved and can never become pending.

Register words, selected by `bus_addr`: 0 pending (write one to clear), 1 enable, 2 route select, 3 sense polarity, 4 sense mode, 5 gated pending (read only), 6 winner index in bits 5:0 (read only). Line n always lives at bit 31−n of a per-line register. A read returns its data on `bus_rdata` one clock after the cycle in which `bus_re` is high.

Top module: `irq_ctrl32`

## Requirements
- R1: Line n occupies bit position 31−n of the pending, enable, route, polarity, mode and gated-pending registers.
- R2: Lines 17, 18 and 19 (bits 14, 13 and 12) always read as zero in the pending, enable and gated-pending registers, and the winner index is never 17, 18 or 19.
- R3: Writing the pending register clears each bit written as one and leaves each bit written as zero unchanged; a pending bit falls only through such a write.
- R4: In level mode (mode bit 0), a line sets its pending bit on every cycle in which it is active, so a clearing write has no lasting effect while the line stays active.
- R5: In edge mode (mode bit 1), a line sets its pending bit once, on entering the active level. The bit stays set after the line goes inactive, and a clearing write while the line is still active leaves it clear.
- R6: Polarity bit 0 makes a line active when low, and polarity bit 1 makes it active when high.
- R7: An enabled pending line with route bit 1 drives `irq_norm`, and one with route bit 0 drives `irq_mcheck`. Each output is low when no enabled pending line is routed to it.
- R8: The gated-pending register reads as pending AND enable. A disabled line still latches its pending bit.
- R9: `pend_idx` and register 6 report the lowest-numbered line that is set in gated pending, or 32 when none is set.
- R10: After reset, the enable, polarity and mode registers read as zero and the route register reads as all ones.
- R11: A change on `irq_src` reaches the pending register on the third rising clock edge after it is applied. The request outputs follow in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | AW (3) | Register word select |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one clock after the strobe |
| irq_src | input | 32 | Asynchronous interrupt lines, bit n is line n |
| irq_norm | output | 1 | Ordinary interrupt request |
| irq_mcheck | output | 1 | Machine-check request |
| pend_idx | output | 6 | Winning line number, 32 when idle |

## Verification
The bench builds the block with its default parameters: a three-bit word address and the reserved-line mask covering lines 17 to 19. With these values every register, including the read-only winner word and the unused eighth address, can be reached. Random polarity and mode settings combine with random line activity, so the priority encoder, the reserved-line blocking and the interaction between clearing writes and level-mode re-setting are all exercised. Directed phases pin down the three-edge input latency and the edge-versus-level clearing behaviour at exact cycles.

// File: rtl/irq_ctrl32.sv
module irq_ctrl32 #(
  parameter int          AW   = 3,
  parameter logic [31:0] RSVD = 32'h0000_7000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [31:0]   bus_rdata,
  input  logic [31:0]   irq_src,
  output logic          irq_norm,
  output logic          irq_mcheck,
  output logic [5:0]    pend_idx
);
  localparam logic [AW-1:0] A_PEND = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);
  localparam logic [AW-1:0] A_RTE  = AW'(2);
  localparam logic [AW-1:0] A_POL  = AW'(3);
  localparam logic [AW-1:0] A_MODE = AW'(4);
  localparam logic [AW-1:0] A_GATE = AW'(5);
  localparam logic [AW-1:0] A_WIN  = AW'(6);

  logic [31:0] src_b, sync1, sync2, sync3;
  logic [31:0] pend_q, en_q, rte_q, pol_q, mode_q;
  logic [31:0] act_now, act_old, hit, clr, gated;
  logic [5:0]  win;

  always_comb
    for (int b = 0; b < 32; b++) src_b[b] = irq_src[31-b];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= src_b;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  assign act_now = ~(sync2 ^ pol_q);
  assign act_old = ~(sync3 ^ pol_q);
  assign hit     = (mode_q & act_now & ~act_old) | (~mode_q & act_now);
  assign clr     = (bus_we && bus_addr == A_PEND) ? bus_wdata : '0;
  assign gated   = pend_q & en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
      rte_q  <= '1;
      pol_q  <= '0;
      mode_q <= '0;
    end else begin
      pend_q <= ((pend_q & ~clr) | hit) & ~RSVD;
      if (bus_we) begin
        case (bus_addr)
          A_EN:    en_q   <= bus_wdata & ~RSVD;
          A_RTE:   rte_q  <= bus_wdata;
          A_POL:   pol_q  <= bus_wdata;
          A_MODE:  mode_q <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    win = 6'd32;
    for (int b = 0; b < 32; b++)
      if (gated[b]) win = 6'(31 - b);
  end

  assign pend_idx   = win;
  assign irq_norm   = |(gated & rte_q);
  assign irq_mcheck = |(gated & ~rte_q);

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_re) begin
      case (bus_addr)
        A_PEND:  bus_rdata <= pend_q;
        A_EN:    bus_rdata <= en_q;
        A_RTE:   bus_rdata <= rte_q;
        A_POL:   bus_rdata <= pol_q;
        A_MODE:  bus_rdata <= mode_q;
        A_GATE:  bus_rdata <= gated;
        A_WIN:   bus_rdata <= {26'd0, win};
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

module irq_ctrl32_chk #(parameter int AW = 3) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic          we,
  input logic          irq_norm,
  input logic          irq_mcheck,
  input logic [5:0]    pend_idx,
  input logic [31:0]   pend
);
  logic [31:0] wr_clr;
  assign wr_clr = (we && addr == AW'(0)) ? wdata : '0;

  assert_idx_range_R9: assert property (@(posedge clk) disable iff (rst)
    pend_idx <= 6'd32);
  assert_idx_rsvd_R2: assert property (@(posedge clk) disable iff (rst)
    !(pend_idx >= 6'd17 && pend_idx <= 6'd19));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    pend_idx == 6'd32 |-> !irq_norm && !irq_mcheck);
  assert_busy_req_R7: assert property (@(posedge clk) disable iff (rst)
    pend_idx != 6'd32 |-> irq_norm || irq_mcheck);
  assert_fall_by_write_R3: assert property (@(posedge clk) disable iff (rst)
    (($past(pend) & ~pend) & ~$past(wr_clr)) == 32'd0);
endmodule

bind irq_ctrl32 irq_ctrl32_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
  .irq_norm(irq_norm), .irq_mcheck(irq_mcheck), .pend_idx(pend_idx),
  .pend(pend_q)
);

// File: tb/tb_irq_ctrl32.sv
module tb_irq_ctrl32;
  logic clk = 0, rst = 1;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, irq_src = 0, bus_rdata;
  logic bus_we = 0, bus_re = 0, irq_norm, irq_mcheck;
  logic [5:0] pend_idx;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_ctrl32 dut (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_src(irq_src),
    .irq_norm(irq_norm), .irq_mcheck(irq_mcheck), .pend_idx(pend_idx));

  // reference model, vectors indexed by line number
  logic [31:0] q1, q2, q3, ms, me, mc, mp, mt, ns, mrd;
  localparam logic [31:0] RSV_L = 32'h000E_0000;

  function automatic logic [31:0] rev(input logic [31:0] v);
    for (int n = 0; n < 32; n++) rev[31-n] = v[n];
  endfunction
  function automatic int widx();
    for (int n = 0; n < 32; n++) if (ms[n] && me[n]) return n;
    return 32;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q1 = 0; q2 = 0; q3 = 0; ms = 0; me = 0; mc = '1; mp = 0; mt = 0; mrd = 0;
    end else begin
      if (bus_re)
        case (bus_addr)
          0: mrd = rev(ms);  1: mrd = rev(me);  2: mrd = rev(mc);
          3: mrd = rev(mp);  4: mrd = rev(mt);  5: mrd = rev(ms & me);
          6: mrd = widx();   default: mrd = 0;
        endcase
      for (int n = 0; n < 32; n++) begin
        bit a2, a3, h, c;
        a2 = (q2[n] == mp[n]);
        a3 = (q3[n] == mp[n]);
        h = mt[n] ? (a2 && !a3) : a2;
        c = bus_we && bus_addr == 0 && bus_wdata[31-n];
        ns[n] = RSV_L[n] ? 1'b0 : ((ms[n] && !c) || h);
      end
      if (bus_we)
        case (bus_addr)
          1: me = rev(bus_wdata) & ~RSV_L;
          2: mc = rev(bus_wdata);
          3: mp = rev(bus_wdata);
          4: mt = rev(bus_wdata);
          default: ;
        endcase
      ms = ns; q3 = q2; q2 = q1; q1 = irq_src;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R7 model irq_norm", irq_norm, |(ms & me & mc));
    chk("R7 model irq_mcheck", irq_mcheck, |(ms & me & ~mc));
    chk("R9 model pend_idx", pend_idx, widx());
    chk("R8 model rdata", bus_rdata, mrd);
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); bus_addr = 3'(a); bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask
  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); bus_addr = 3'(a); bus_re = 1;
    @(negedge clk); bus_re = 0; d = bus_rdata;
  endtask
  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask
  task automatic clean();
    irq_src = 0;
    wr(3, '1); wr(4, 0); wr(1, 0); wr(2, '1);
    cyc(4); wr(0, '1); cyc(1);
  endtask

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    cyc(4); rst = 0;
    rd(1, v); chk("R10 enable reset", v, 0);
    rd(2, v); chk("R10 route reset", v, 32'hFFFF_FFFF);
    rd(3, v); chk("R10 polarity reset", v, 0);
    rd(4, v); chk("R10 mode reset", v, 0);

    clean();
    rd(0, v); chk("R3 clear all", v, 0);
    irq_src[5] = 1; cyc(4);
    rd(0, v); chk("R1 line 5 at bit 26", v, 32'h0400_0000);
    rd(5, v); chk("R8 disabled line latched, gated zero", v, 0);
    rd(6, v); chk("R9 idle index", v, 32);
    wr(0, 32'h0400_0000); cyc(1);
    rd(0, v); chk("R4 level re-set while active", v, 32'h0400_0000);
    irq_src[5] = 0; cyc(4);
    wr(0, 32'hFBFF_FFFF); rd(0, v); chk("R3 zero write keeps bit", v, 32'h0400_0000);
    wr(0, 32'h0400_0000); rd(0, v); chk("R3 one write clears", v, 0);

    wr(4, 32'h0080_0000); irq_src[8] = 1; cyc(4);
    rd(0, v); chk("R5 edge sets", v, 32'h0080_0000);
    wr(0, 32'h0080_0000); cyc(2);
    rd(0, v); chk("R5 edge stays clear while active", v, 0);
    irq_src[8] = 0; cyc(4); irq_src[8] = 1; cyc(4); irq_src[8] = 0; cyc(4);
    rd(0, v); chk("R5 edge held after release", v, 32'h0080_0000);

    clean();
    wr(3, 32'hEFFF_FFFF); cyc(4);
    rd(0, v); chk("R6 active-low line 3", v, 32'h1000_0000);
    wr(3, '1); cyc(4); wr(0, '1); cyc(1);
    rd(0, v); chk("R6 active-high low line idle", v, 0);

    clean();
    wr(2, 32'hFF7F_FFFF); wr(1, 32'h0480_0000);
    irq_src[5] = 1; irq_src[8] = 1; cyc(4);
    chk("R7 normal request", irq_norm, 1);
    chk("R7 machine-check request", irq_mcheck, 1);
    rd(6, v); chk("R9 lowest wins", v, 5);
    irq_src[5] = 0; cyc(4); wr(0, 32'h0400_0000); cyc(1);
    chk("R7 normal drops", irq_norm, 0);
    chk("R9 next winner", pend_idx, 8);

    clean();
    wr(1, '1); rd(1, v); chk("R2 enable reserved zero", v, 32'hFFFF_8FFF);
    irq_src[19:17] = 3'b111; cyc(4);
    rd(0, v); chk("R2 pending reserved zero", v, 0);
    rd(5, v); chk("R2 gated reserved zero", v, 0);
    chk("R2 index not reserved", pend_idx, 32);

    clean(); wr(1, 32'h0400_0000);
    @(negedge clk); irq_src[5] = 1;
    cyc(2); chk("R11 not yet after two edges", irq_norm, 0);
    cyc(1); chk("R11 seen after three edges", irq_norm, 1);

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0) irq_src = $urandom;
      bus_addr = 3'($urandom_range(7));
      bus_wdata = $urandom;
      bus_we = ($urandom_range(5) == 0);
      bus_re = ($urandom_range(1) == 0);
    end
    @(negedge clk); bus_we = 0; bus_re = 0;
    cyc(2);
    finish_up();
  end
endmodule